// File: doc/BRIEF.md
# Timer Count-Enable Generator

This block turns the system clock into count-enable pulses for a pair of timers. A single free-running divider chain is shared by both timers. Each timer has its own 3-bit source-select field. That field picks one of four things: no counting, every clock, one of four divided rates, or an edge of that timer's external clock pin. Each timer receives a registered pulse, one clock wide, on every cycle in which its counter should advance. The counters themselves live elsewhere.

A small control register gives software two levers. The first is a prescaler-clear bit, which restarts the shared divider, so it moves both timers' divided rates at once. The second is a hold bit, which freezes every timer and the divider. While the hold bit is set, several timers can be set up and then released on the same cycle. The external pins go through a two-stage synchronizer before edge detection. Each pin is always treated as a count source when selected, whatever direction the pin has elsewhere on the chip.

Top module: `timer_tick_gen`

## Requirements
- R1: During and right after synchronous reset every `tick` bit is 0 and `ctl_q` reads 0x00.
- R2: Select code 0 produces no tick on that timer.
- R3: Select code 1 produces a tick in every cycle following a cycle in which the hold bit is clear.
- R4: Select codes 2, 3, 4 and 5 produce one tick per 8, 64, 256 and 1024 clocks of the shared 10-bit divider. A tick is due one cycle after the divider's low 3, 6, 8 or 10 bits are all zero. Both timers see the same divider, so equal codes tick together.
- R5: Select code 6 counts falling edges of that timer's `ext_clk_pin`. A level change first captured at clock edge k gives a tick during the cycle after edge k+2.
- R6: Select code 7 counts rising edges of `ext_clk_pin`, with the same latency as R5.
- R7: Writing `ctl_wr_data` bit 0 = 1 sets the prescaler-clear bit. While the bit is set, no divided rate ticks. On the edge after it is seen, the divider is zeroed, so every divided code ticks in the cycle after that.
- R8: While `ctl_q` bit 7 (hold) is 1, no timer ticks under any code, and the divider does not advance. A prescaler-clear bit written together with hold stays set.
- R9: `ctl_q` shows hold in bit 7 and prescaler-clear in bit 0, with all other bits 0. When hold is 0 and no write occurs, hardware clears bit 0 one cycle later, and counting resumes.
- R10: Ticks are single-cycle pulses. Under a steady divided code, a tick is never followed by another tick in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | N_TIMERS x 3 | Per-timer count-source select code |
| ext_clk_pin | input | N_TIMERS | Per-timer external count pin, asynchronous |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write data (bit 7 hold, bit 0 prescaler clear) |
| ctl_q | output | 8 | Current control register contents |
| tick | output | N_TIMERS | Per-timer count-enable pulse |

## Verification
The bench builds the block with its defaults: two timers, a 10-bit divider and two synchronizer stages. At those values a full 1024-clock period fits inside each 2100-cycle window of the code sweep. In that sweep every code runs on one timer while the other timer uses a different code, and the external pins toggle from an LFSR. Afterwards every one of the 64 select pairs is applied briefly. Prescaler clears, hold-with-clear, and hold without clear are each applied at varied divider phases. A cycle-level model computed in the bench shows that the divider resumes from its frozen phase after a hold.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

  localparam int SEL_W    = 3;
  localparam int CTL_W    = 8;
  localparam int HOLD_BIT = 7;
  localparam int PCLR_BIT = 0;
  localparam int NUM_TAPS = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF      = 3'd0,
    SRC_DIV1     = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } src_sel_e;

  // number of low divider bits that must be zero for each tap
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tick_gen_ctl.sv
module tick_gen_ctl
  import tick_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic             hold,
  output logic             pclr,
  output logic [CTL_W-1:0] ctl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= 1'b0;
      pclr <= 1'b0;
    end else if (wr_en) begin
      hold <= wr_data[HOLD_BIT];
      pclr <= wr_data[PCLR_BIT];
    end else if (!hold) begin
      pclr <= 1'b0;  // self-clearing once hold is released
    end
  end

  always_comb begin
    ctl_q           = '0;
    ctl_q[HOLD_BIT] = hold;
    ctl_q[PCLR_BIT] = pclr;
  end

endmodule

// File: rtl/tick_gen_prescale.sv
module tick_gen_prescale
  import tick_gen_pkg::*;
#(
  parameter int TAPS = NUM_TAPS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            freeze,
  output logic [TAPS-1:0] tap_zero
);

  localparam int CNT_W = tap_log2(TAPS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (!freeze) cnt <= cnt + 1'b1;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam int LB = tap_log2(t);
    assign tap_zero[t] = !clr && (cnt[LB-1:0] == '0);
  end

endmodule

// File: rtl/tick_gen_extsync.sv
module tick_gen_extsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      last <= sh[STAGES-1];
    end
  end

  assign rise =  sh[STAGES-1] && !last;
  assign fall = !sh[STAGES-1] &&  last;

endmodule

// File: rtl/tick_gen_select.sv
module tick_gen_select
  import tick_gen_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic                ext_rise,
  input  logic                ext_fall,
  input  logic                hold,
  output logic                tick
);

  logic hit;

  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_OFF:      hit = 1'b0;
      SRC_DIV1:     hit = 1'b1;
      SRC_DIV8:     hit = taps[0];
      SRC_DIV64:    hit = taps[1];
      SRC_DIV256:   hit = taps[2];
      SRC_DIV1024:  hit = taps[3];
      SRC_EXT_FALL: hit = ext_fall;
      SRC_EXT_RISE: hit = ext_rise;
      default:      hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= hit && !hold;
  end

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import tick_gen_pkg::*;
#(
  parameter int N_TIMERS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_TIMERS-1:0][SEL_W-1:0] clk_sel,
  input  logic [N_TIMERS-1:0]            ext_clk_pin,
  input  logic                           ctl_wr_en,
  input  logic [CTL_W-1:0]               ctl_wr_data,
  output logic [CTL_W-1:0]               ctl_q,
  output logic [N_TIMERS-1:0]            tick
);

  logic                hold;
  logic                pclr;
  logic [NUM_TAPS-1:0] taps;

  tick_gen_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .hold    (hold),
    .pclr    (pclr),
    .ctl_q   (ctl_q)
  );

  tick_gen_prescale #(.TAPS(NUM_TAPS)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (pclr),
    .freeze   (hold),
    .tap_zero (taps)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    logic rise_i;
    logic fall_i;

    tick_gen_extsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin  (ext_clk_pin[i]),
      .rise (rise_i),
      .fall (fall_i)
    );

    tick_gen_select u_sel (
      .clk      (clk),
      .rst      (rst),
      .sel      (clk_sel[i]),
      .taps     (taps),
      .ext_rise (rise_i),
      .ext_fall (fall_i),
      .hold     (hold),
      .tick     (tick[i])
    );
  end

endmodule

// File: rtl/timer_tick_gen_chk.sv
module timer_tick_gen_chk
  import tick_gen_pkg::*;
#(
  parameter int N_TIMERS = 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic [N_TIMERS-1:0][SEL_W-1:0] clk_sel,
  input logic                           ctl_wr_en,
  input logic [CTL_W-1:0]               ctl_q,
  input logic [N_TIMERS-1:0]            tick
);

  // R8: hold blocks every timer on the following cycle
  a_r8_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    ctl_q[HOLD_BIT] |=> (tick == '0));

  // R9: clear bit drops by itself when not held and not written
  a_r9_pclr_selfclear: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[HOLD_BIT] && !ctl_wr_en) |=> !ctl_q[PCLR_BIT]);

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
    // R2: source off never ticks
    a_r2_off_silent: assert property (@(posedge clk) disable iff (rst)
      (clk_sel[i] == 3'd0) |=> !tick[i]);

    // R3: undivided source ticks whenever not held
    a_r3_div1_every: assert property (@(posedge clk) disable iff (rst)
      (clk_sel[i] == 3'd1 && !ctl_q[HOLD_BIT]) |=> tick[i]);

    // R10: a divided tick is one cycle wide
    a_r10_single_width: assert property (@(posedge clk) disable iff (rst)
      (clk_sel[i] == 3'd2 && clk_sel[i] == $past(clk_sel[i]) && tick[i]) |=> !tick[i]);
  end

endmodule

bind timer_tick_gen timer_tick_gen_chk #(.N_TIMERS(N_TIMERS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_sel   (clk_sel),
  .ctl_wr_en (ctl_wr_en),
  .ctl_q     (ctl_q),
  .tick      (tick)
);

// File: tb/timer_tick_gen_test.sv
`timescale 1ns/1ps
module timer_tick_gen_test;

  localparam int NT = 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NT-1:0][2:0]  clk_sel = '0;
  logic [NT-1:0]       ext_clk_pin = '0;
  logic                ctl_wr_en = 1'b0;
  logic [7:0]          ctl_wr_data = '0;
  logic [7:0]          ctl_q;
  logic [NT-1:0]       tick;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  logic [15:0] lf = 16'hACE1;

  // bench-side model state
  logic [9:0]    m_cnt  = '0;
  logic          m_hold = 1'b0;
  logic          m_pclr = 1'b0;
  logic [NT-1:0] m_p1 = '0, m_p2 = '0, m_p3 = '0, m_tick = '0;

  timer_tick_gen #(.N_TIMERS(NT), .SYNC_STAGES(2)) uut (
    .clk (clk), .rst (rst), .clk_sel (clk_sel), .ext_clk_pin (ext_clk_pin),
    .ctl_wr_en (ctl_wr_en), .ctl_wr_data (ctl_wr_data), .ctl_q (ctl_q), .tick (tick)
  );

  always #2.5 clk = ~clk;

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic model_edge();
    logic [NT-1:0] nt;
    for (int i = 0; i < NT; i++) begin
      logic h;
      case (clk_sel[i])
        3'd0: h = 1'b0;
        3'd1: h = 1'b1;
        3'd2: h = !m_pclr && (m_cnt[2:0] == 0);
        3'd3: h = !m_pclr && (m_cnt[5:0] == 0);
        3'd4: h = !m_pclr && (m_cnt[7:0] == 0);
        3'd5: h = !m_pclr && (m_cnt == 0);
        3'd6: h = !m_p2[i] && m_p3[i];
        default: h = m_p2[i] && !m_p3[i];
      endcase
      nt[i] = h && !m_hold;
    end
    if (rst) begin
      m_cnt = '0; m_hold = 0; m_pclr = 0; m_p1 = '0; m_p2 = '0; m_p3 = '0; m_tick = '0;
    end else begin
      m_tick = nt;
      m_cnt  = m_pclr ? 10'd0 : (m_hold ? m_cnt : m_cnt + 10'd1);
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_clk_pin;
      if (ctl_wr_en) begin
        m_hold = ctl_wr_data[7];
        m_pclr = ctl_wr_data[0];
      end else if (!m_hold) begin
        m_pclr = 1'b0;
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int i = 0; i < NT; i++) begin
      string r;
      r = (cur_req == "") ? req_of(clk_sel[i]) : cur_req;
      checks++;
      if (tick[i] !== m_tick[i]) begin
        fails++;
        $display("FAIL %s tick[%0d] sel=%0d actual=%b expected=%b", r, i, clk_sel[i], tick[i], m_tick[i]);
      end
    end
    checks++;
    if (ctl_q !== {m_hold, 6'b0, m_pclr}) begin
      fails++;
      $display("FAIL R9 ctl_q actual=%h expected=%h", ctl_q, {m_hold, 6'b0, m_pclr});
    end
  endtask

  task automatic step_pins();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (lf[4]) ext_clk_pin = lf[1:0];
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      step_pins();
      cyc();
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    step_pins();
    cyc();
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    for (int k = 0; k < 3; k++) cyc();
    rst = 1'b0;
    cyc();

    // R2-R6: every code on timer 0, a different code on timer 1
    cur_req = "";
    for (int c = 0; c < 8; c++) begin
      clk_sel[0] = 3'(c);
      clk_sel[1] = 3'((c + 3) % 8);
      run(2100);
    end
    clk_sel[0] = 3'd4; clk_sel[1] = 3'd4;  // R4: shared divider, equal codes
    run(600);

    // R7: prescaler clear at several phases
    cur_req = "R7";
    clk_sel[0] = 3'd2; clk_sel[1] = 3'd5;
    for (int k = 0; k < 5; k++) begin
      run(37 + 113 * k);
      wr(8'h01);
      run(20);
    end
    clk_sel[0] = 3'd3; clk_sel[1] = 3'd5;
    wr(8'h01);
    run(1100);

    // R8: hold with and without clear, all codes frozen
    cur_req = "R8";
    clk_sel[0] = 3'd1; clk_sel[1] = 3'd7;
    run(13);
    wr(8'h81);
    run(60);
    clk_sel[0] = 3'd6; clk_sel[1] = 3'd2;
    run(40);
    cur_req = "R9";
    wr(8'h00);
    run(300);
    cur_req = "R8";
    run(5);
    wr(8'h80);
    run(45);
    cur_req = "R9";
    wr(8'h00);
    clk_sel[0] = 3'd4; clk_sel[1] = 3'd3;
    run(600);

    // R10: every select pair
    cur_req = "R10";
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        clk_sel[0] = 3'(a); clk_sel[1] = 3'(b);
        run(30);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule